// File: doc/BRIEF.md
# Lane-Chained Vector Add/Subtract with Carry

This block adds or subtracts two 128-bit vectors that are split into four 32-bit lanes. The carry does not stay inside a lane. The carry out of each lane feeds the carry in of the next higher lane, so the whole vector behaves like one long adder with per-lane write control. Lane 0 occupies bits [31:0] and lane 3 occupies bits [127:96]. The subtract form adds the bitwise inverse of the second operand, so the carry acts as an inverted borrow.

The carry into lane 0 comes from one of two places, chosen by a mode bit: a constant 1, or the incoming carry flag. The carry out of the top lane becomes the new carry flag. A 4-bit lane enable masks individual lanes. A masked lane returns the old destination value and passes its incoming carry straight through. All four lanes are computed from the operands presented in one cycle, so a destination that overlaps a source still sees the original values. The result, the new flag and a valid strobe are registered, and appear one cycle after the request.

Top module: `vadc_chain`

## Requirements
- R1: One clock after a cycle with `req_valid`=1, `res_valid` is 1. After a cycle with `req_valid`=0, `res_valid` is 0.
- R2: Add mode (`op_sub`=0). Each enabled lane k (bits 32k+31:32k) returns (A_k + B_k + c_k) mod 2^32. The carry out of lane k is c_(k+1), and lane 0 is bits [31:0].
- R3: Subtract mode (`op_sub`=1). Each enabled lane returns (A_k + ~B_k + c_k) mod 2^32. The carry chain works the same way as in add mode.
- R4: The carry into lane 0 is 1 when `seed_one`=1. Otherwise it is `flag_in`.
- R5: A lane whose bit in `lane_en` is 0 returns the matching lane of `dst_old`. It passes its incoming carry unchanged to the next lane.
- R6: When `lane_en[3]`=1, `flag_out` becomes the carry out of lane 3. When `lane_en[3]`=0, `flag_out` becomes `flag_in`.
- R7: After synchronous reset, `res_valid`, `result` and `flag_out` are all 0.
- R8: In a cycle with `req_valid`=0, `result` and `flag_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 1 selects subtract (A + ~B + carry) |
| seed_one | input | 1 | 1 seeds lane 0 with a constant 1; 0 uses flag_in |
| flag_in | input | 1 | Current carry flag |
| lane_en | input | 4 | Per-lane write enable |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| dst_old | input | 128 | Previous destination value |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| result | output | 128 | Registered result vector |
| flag_out | output | 1 | Registered new carry flag |

## Verification
Two functions can fall in the same cycle: a carry that ripples into the top lane, and masking of that top lane. In that case the flag must keep `flag_in` even though a carry is present at lane 3. The bench provokes this with all-ones operands, a seed of 1 and `lane_en[3]`=0, and expects `flag_out` to equal `flag_in` while the lower lanes hold the rippled zeros. In a second case a masked middle lane sits between a carry-producing lane and an enabled lane. The bench checks that the carry passes through the masked lane into the lane above it.

// File: rtl/vadc_pkg.sv
package vadc_pkg;
  parameter int unsigned LANE_W = 32;
  parameter int unsigned LANES  = 4;
  parameter int unsigned VEC_W  = LANE_W * LANES;

  typedef struct packed {
    logic sub;
    logic seed_one;
  } vadc_mode_t;
endpackage

// File: rtl/vadc_lane.sv
module vadc_lane #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] old,
  input  logic         sub,
  input  logic         en,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0]   sum;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    if (en) begin
      res  = sum[W-1:0];
      cout = sum[W];
    end else begin
      res  = old;
      cout = cin;
    end
  end
endmodule

// File: rtl/vadc_ripple.sv
module vadc_ripple #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4,
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] old,
  input  logic             sub,
  input  logic [LANES-1:0] en,
  input  logic             seed,
  output logic [VEC_W-1:0] res,
  output logic             top_cout
);
  logic [LANES:0] chain;

  assign chain[0] = seed;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vadc_lane #(.W(LANE_W)) i_lane (
      .a   (a[k*LANE_W +: LANE_W]),
      .b   (b[k*LANE_W +: LANE_W]),
      .old (old[k*LANE_W +: LANE_W]),
      .sub (sub),
      .en  (en[k]),
      .cin (chain[k]),
      .res (res[k*LANE_W +: LANE_W]),
      .cout(chain[k+1])
    );
  end

  assign top_cout = chain[LANES];
endmodule

// File: rtl/vadc_chain.sv
module vadc_chain
  import vadc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             op_sub,
  input  logic             seed_one,
  input  logic             flag_in,
  input  logic [LANES-1:0] lane_en,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] dst_old,
  output logic             res_valid,
  output logic [VEC_W-1:0] result,
  output logic             flag_out
);
  vadc_mode_t       mode;
  logic             seed;
  logic [VEC_W-1:0] sum_vec;
  logic             top_cout;
  logic             flag_next;

  assign mode = '{sub: op_sub, seed_one: seed_one};
  assign seed = mode.seed_one ? 1'b1 : flag_in;

  vadc_ripple #(.LANE_W(LANE_W), .LANES(LANES)) i_ripple (
    .a       (src_a),
    .b       (src_b),
    .old     (dst_old),
    .sub     (mode.sub),
    .en      (lane_en),
    .seed    (seed),
    .res     (sum_vec),
    .top_cout(top_cout)
  );

  assign flag_next = lane_en[LANES-1] ? top_cout : flag_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      flag_out  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        result   <= sum_vec;
        flag_out <= flag_next;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R1
  AST_MASKED_LANE0_OLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !lane_en[0]) |=> result[LANE_W-1:0] == $past(dst_old[LANE_W-1:0])); // R5
  AST_TOP_MASK_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !lane_en[LANES-1]) |=> flag_out == $past(flag_in)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(result) && $stable(flag_out))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!res_valid && result == '0 && !flag_out)); // R7
endmodule

// File: tb/test_vadc_chain.sv
module test_vadc_chain;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 32;
  localparam int NL = 4;
  localparam int VW = LW * NL;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, op_sub, seed_one, flag_in;
  logic [NL-1:0] lane_en;
  logic [VW-1:0] src_a, src_b, dst_old;
  logic          res_valid;
  logic [VW-1:0] result;
  logic          flag_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vadc_chain i_vadc_chain (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_sub(op_sub),
    .seed_one(seed_one), .flag_in(flag_in), .lane_en(lane_en),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .res_valid(res_valid), .result(result), .flag_out(flag_out)
  );

  function automatic logic [VW:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                        input logic [VW-1:0] old, input logic sub,
                                        input logic seed1, input logic fl, input logic [NL-1:0] en);
    logic [VW-1:0] r;
    logic          c;
    logic [LW:0]   s;
    logic          f;
    c = seed1 ? 1'b1 : fl;
    f = fl;
    for (int k = 0; k < NL; k++) begin
      s = {1'b0, a[k*LW +: LW]} + {1'b0, (sub ? ~b[k*LW +: LW] : b[k*LW +: LW])} + {{LW{1'b0}}, c};
      if (en[k]) begin
        r[k*LW +: LW] = s[LW-1:0];
        c = s[LW];
        if (k == NL-1) f = c;
      end else begin
        r[k*LW +: LW] = old[k*LW +: LW];
      end
    end
    return {f, r};
  endfunction

  task automatic check(input string req, input logic [VW:0] act, input logic [VW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic [VW-1:0] old, input logic sub, input logic seed1,
                        input logic fl, input logic [NL-1:0] en);
    logic [VW:0] exp;
    exp = model(a, b, old, sub, seed1, fl, en);
    req_valid = 1'b1; src_a = a; src_b = b; dst_old = old;
    op_sub = sub; seed_one = seed1; flag_in = fl; lane_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    src_a = ~a; src_b = ~b; dst_old = ~old; flag_in = ~fl; lane_en = ~en;
    check({req, " R1 valid"}, {{VW{1'b0}}, res_valid}, {{VW{1'b0}}, 1'b1});
    check(req, {flag_out, result}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VW:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; req_valid = 1'b0; op_sub = 1'b0; seed_one = 1'b0; flag_in = 1'b0;
    lane_en = '0; src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check("R7 reset", {flag_out, result}, '0);
    check("R7 reset valid", {{VW{1'b0}}, res_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid low", {{VW{1'b0}}, res_valid}, '0);

    // R2: carry ripples through all lanes
    run_op("R2 full ripple", {VW{1'b1}}, '0, '0, 1'b0, 1'b1, 1'b0, 4'hF);
    check("R2 ripple value", {flag_out, result}, {1'b1, {VW{1'b0}}});
    // R4: flag seed vs constant seed
    run_op("R4 seed from flag=0", 128'h5, 128'h3, '0, 1'b0, 1'b0, 1'b0, 4'hF);
    check("R4 lane0 sum 8", {{VW-31{1'b0}}, result[31:0]}, {{VW-31{1'b0}}, 32'h8});
    run_op("R4 seed from flag=1", 128'h5, 128'h3, '0, 1'b0, 1'b0, 1'b1, 4'hF);
    check("R4 lane0 sum 9", {{VW-31{1'b0}}, result[31:0]}, {{VW-31{1'b0}}, 32'h9});
    // R3: equal operands subtract with seed 1 gives zero and carry 1
    run_op("R3 equal sub", {4{32'hDEADBEEF}}, {4{32'hDEADBEEF}}, '1, 1'b1, 1'b1, 1'b0, 4'hF);
    check("R3 zero result", {flag_out, result}, {1'b1, {VW{1'b0}}});
    run_op("R3 borrow", '0, 128'h1, '0, 1'b1, 1'b1, 1'b0, 4'hF);
    check("R3 borrow all ones", {flag_out, result}, {1'b0, {VW{1'b1}}});
    // R5: masked middle lane passes carry through
    run_op("R5 pass-through", {32'h0, 32'h0, 32'h0, 32'hFFFFFFFF}, '0,
           {4{32'hA5A5A5A5}}, 1'b0, 1'b1, 1'b0, 4'b1101);
    check("R5 carry reaches lane2", {1'b0, result}, {1'b0, 32'h0, 32'h1, 32'hA5A5A5A5, 32'h0});
    // R6: top lane masked while carry reaches it
    run_op("R6 top masked flag0", {VW{1'b1}}, '0, {4{32'h12345678}}, 1'b0, 1'b1, 1'b0, 4'b0111);
    check("R6 flag kept 0", {{VW{1'b0}}, flag_out}, '0);
    run_op("R6 top masked flag1", '0, '0, '0, 1'b0, 1'b0, 1'b1, 4'b0111);
    run_op("R5 all masked", {VW{1'b1}}, {VW{1'b1}}, {4{32'hCAFEF00D}}, 1'b1, 1'b1, 1'b0, 4'h0);
    // R8: idle holds outputs
    held = {flag_out, result};
    repeat (3) @(negedge clk);
    check("R8 hold", {flag_out, result}, held);
    check("R1 valid drop", {{VW{1'b0}}, res_valid}, '0);

    for (int n = 0; n < 300; n++) begin
      logic [VW-1:0] ra, rb, ro;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      ro = {$urandom, $urandom, $urandom, $urandom};
      if (n % 5 == 0) rb = ~ra;
      run_op((n % 2 == 0) ? "R2 random" : "R3 random", ra, rb, ro, n[0],
             1'($urandom), 1'($urandom), 4'($urandom));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 reset again", {flag_out, result}, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule